// File: doc/BRIEF.md
# Error Status Capture for a Local Interrupt Controller

This block sits inside a local interrupt controller and collects the error events that the rest of the controller reports. Each cycle it takes a vector of error event bits. It merges them into a hidden pending register. Software never sees the pending register directly. The readable status register is a snapshot. It changes only when software writes the status register. That write discards its data, copies the pending errors into the snapshot and empties the pending register.

The block also decides when to request the error interrupt. The request is made only on the first error after an arm point. Reset is an arm point, and so is every status write. The vector and the mask come from the error entry of the local vector table. If the vector is too small to be legal, the block records a receive-illegal-vector error in the same update. When the controller runs in the extended register mode, only a zero write to the status register is legal. A nonzero write in that mode still does its normal work, and it also raises a one-cycle illegal-write flag.

Top module: `lic_errstat`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `reg_rdata`, `irq_req` and `illegal_wr` are all zero, and the pending register is empty.
- R2: Error events never change `reg_rdata` directly. `reg_rdata` changes only in the cycle after a cycle with `reg_wr` high.
- R3: When `reg_wr` is high in a cycle, `reg_rdata` in the next cycle equals the OR of all error bits collected in earlier cycles since the previous write. This includes any bit added by R9. The pending register is emptied, and the value of `reg_wdata` has no effect on the result.
- R4: A write with `x2_mode` high and nonzero `reg_wdata` drives `illegal_wr` high for exactly the next cycle and still performs the R3 latch. Any other write, and any cycle with no write, leaves `illegal_wr` low.
- R5: A cycle with a nonzero `err_evt` fires the interrupt when the pending register is empty before that event. The pending register counts as empty after the clear made by a same-cycle write. When the interrupt fires, `irq_req` is high for the next cycle only.
- R6: Once the pending register holds any bit, later error events raise no interrupt until a status write empties it. An event whose bits are all already pending changes nothing.
- R7: While `irq_req` is high, `irq_vec` equals bits 7:0 of `lvt_err` from the cycle the interrupt fired.
- R8: If bit 16 of `lvt_err` is set when the interrupt fires, `irq_req` stays low. The errors are still collected, and the arm point is still used up.
- R9: When the interrupt fires and bits 7:0 of `lvt_err` are below 16, status bit 6 (receive illegal vector) is added to the pending errors in the same update. This happens whether or not the entry is masked.
- R10: Status bits are: 0 send checksum, 1 receive checksum, 2 send accept, 3 receive accept, 4 redirectable IPI, 5 send illegal vector, 6 receive illegal vector, 7 illegal register address. Bits 31:8 of `reg_rdata` always read zero.
- R11: An error event in the same cycle as a write is not part of that write's snapshot. It lands in the freshly emptied pending register and shows up at the following write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| err_evt | input | 8 | Error events detected this cycle, one bit per status bit |
| reg_wr | input | 1 | Write strobe for the status register |
| reg_wdata | input | 32 | Write data; only checked against zero in extended mode |
| x2_mode | input | 1 | Extended register mode; only zero writes are legal |
| lvt_err | input | 32 | Error entry of the local vector table (vector 7:0, mask 16) |
| reg_rdata | output | 32 | Status snapshot, zero-extended |
| irq_req | output | 1 | One-cycle error interrupt request |
| irq_vec | output | 8 | Vector of the error interrupt, valid with `irq_req` |
| illegal_wr | output | 1 | One-cycle flag for a nonzero write in extended mode |

## Verification
The bench builds the block with its default sizes: eight status bits, a 32-bit data path, an 8-bit vector and an illegal-vector limit of 16. Every vector from 0 to 31, with the mask both clear and set, can therefore be tried, which covers the legal/illegal boundary at 15/16 in both mask states. Every one of the 256 event patterns can be applied against both an empty and a non-empty pending register, and each snapshot is compared with a model built from R3 and R9. Writes are tried in both modes with zero and nonzero data, and each write is also combined with a same-cycle event.

// File: rtl/lic_errstat_pkg.sv
package lic_errstat_pkg;
   // Status bit positions that the block relies on
   localparam int unsigned ST_RX_BADVEC = 6;
   localparam int unsigned ST_COUNT     = 8;

   // Decoded error entry of the local vector table
   typedef struct packed {
      logic [7:0] vec;
      logic       masked;
      logic       bad;
   } lvt_dec_t;
endpackage

// File: rtl/lic_errstat_lvtdec.sv
module lic_errstat_lvtdec #(
   parameter int unsigned LVT_W    = 32,
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned MIN_VEC  = 16,
   parameter int unsigned MASK_POS = 16
) (
   input  logic [LVT_W-1:0] lvt,
   output logic [VEC_W-1:0] vec,
   output logic             masked,
   output logic             vec_bad
);
   localparam logic [VEC_W-1:0] LIMIT = VEC_W'(MIN_VEC);

   assign vec     = lvt[VEC_W-1:0];
   assign masked  = lvt[MASK_POS];
   assign vec_bad = (vec < LIMIT);

   logic unused_lvt;
   assign unused_lvt = ^lvt;
endmodule

// File: rtl/lic_errstat_arm.sv
module lic_errstat_arm #(
   parameter int unsigned ERR_W   = 8,
   parameter int unsigned RIV_IDX = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ERR_W-1:0] evt,
   input  logic             wr,
   input  logic             vec_bad,
   output logic [ERR_W-1:0] pend_q,
   output logic             fire
);
   logic [ERR_W-1:0] base;
   logic [ERR_W-1:0] pend_d;
   logic             armed;

   // A same-cycle write empties the pending set before the event merges
   assign base  = wr ? '0 : pend_q;
   assign armed = ~|base;
   assign fire  = armed & (|evt);

   for (genvar i = 0; i < ERR_W; i++) begin : g_bit
      if (i == RIV_IDX) begin : g_riv
         assign pend_d[i] = base[i] | evt[i] | (fire & vec_bad);
      end else begin : g_plain
         assign pend_d[i] = base[i] | evt[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end
endmodule

// File: rtl/lic_errstat_snap.sv
module lic_errstat_snap #(
   parameter int unsigned ERR_W  = 8,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              x2,
   input  logic [ERR_W-1:0]  pend_q,
   output logic [DATA_W-1:0] rdata,
   output logic              ill_q
);
   logic [ERR_W-1:0] vis_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vis_q <= '0;
         ill_q <= 1'b0;
      end else begin
         if (wr) vis_q <= pend_q;
         ill_q <= wr & x2 & (|wdata);
      end
   end

   if (DATA_W > ERR_W) begin : g_pad
      assign rdata = {{(DATA_W-ERR_W){1'b0}}, vis_q};
   end else begin : g_flat
      assign rdata = vis_q;
   end
endmodule

// File: rtl/lic_errstat.sv
module lic_errstat
   import lic_errstat_pkg::*;
#(
   parameter int unsigned ERR_W    = ST_COUNT,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned LVT_W    = 32,
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned MIN_VEC  = 16,
   parameter int unsigned MASK_POS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ERR_W-1:0]  err_evt,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              x2_mode,
   input  logic [LVT_W-1:0]  lvt_err,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vec,
   output logic              illegal_wr
);
   if (ERR_W > DATA_W)        begin : g_bad_w   $error("ERR_W exceeds DATA_W");   end
   if (ERR_W <= ST_RX_BADVEC) begin : g_bad_riv $error("ERR_W too small");         end
   if (VEC_W > LVT_W)         begin : g_bad_v   $error("VEC_W exceeds LVT_W");     end
   if (MASK_POS >= LVT_W)     begin : g_bad_m   $error("MASK_POS outside entry");  end
   if (MASK_POS < VEC_W)      begin : g_bad_o   $error("mask overlaps vector");    end

   logic [VEC_W-1:0] dec_vec;
   logic             dec_masked;
   logic             dec_bad;
   logic [ERR_W-1:0] pend_q;
   logic             fire;
   logic             irq_q;
   logic [VEC_W-1:0] vec_q;

   lic_errstat_lvtdec #(
      .LVT_W(LVT_W), .VEC_W(VEC_W), .MIN_VEC(MIN_VEC), .MASK_POS(MASK_POS)
   ) u_dec (
      .lvt(lvt_err), .vec(dec_vec), .masked(dec_masked), .vec_bad(dec_bad)
   );

   lic_errstat_arm #(
      .ERR_W(ERR_W), .RIV_IDX(ST_RX_BADVEC)
   ) u_arm (
      .clk(clk), .rst_n(rst_n), .evt(err_evt), .wr(reg_wr),
      .vec_bad(dec_bad), .pend_q(pend_q), .fire(fire)
   );

   lic_errstat_snap #(
      .ERR_W(ERR_W), .DATA_W(DATA_W)
   ) u_snap (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata), .x2(x2_mode),
      .pend_q(pend_q), .rdata(reg_rdata), .ill_q(illegal_wr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         vec_q <= '0;
      end else begin
         irq_q <= fire & ~dec_masked;
         if (fire) vec_q <= dec_vec;
      end
   end

   assign irq_req = irq_q;
   assign irq_vec = vec_q;
endmodule

// File: rtl/lic_errstat_chk.sv
module lic_errstat_chk #(
   parameter int unsigned ERR_W    = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned LVT_W    = 32,
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned MASK_POS = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ERR_W-1:0]  err_evt,
   input logic              reg_wr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              x2_mode,
   input logic [LVT_W-1:0]  lvt_err,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              irq_req,
   input logic [VEC_W-1:0]  irq_vec,
   input logic              illegal_wr
);
   logic unused_chk;
   assign unused_chk = ^err_evt;

   p_snap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> $stable(reg_rdata));

   p_bad_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && x2_mode && (reg_wdata != '0)) |=> illegal_wr);

   p_quiet_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr || !x2_mode || (reg_wdata == '0)) |=> !illegal_wr);

   p_single_shot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !reg_wr) |=> !irq_req);

   p_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req ##1 irq_req |-> irq_vec == $past(lvt_err[VEC_W-1:0]));

   p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lvt_err[MASK_POS] |=> !irq_req);

   p_high_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DATA_W-1:ERR_W] == '0);
endmodule

bind lic_errstat lic_errstat_chk #(
   .ERR_W(ERR_W), .DATA_W(DATA_W), .LVT_W(LVT_W), .VEC_W(VEC_W), .MASK_POS(MASK_POS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .reg_wr(reg_wr),
   .reg_wdata(reg_wdata), .x2_mode(x2_mode), .lvt_err(lvt_err),
   .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
   .illegal_wr(illegal_wr)
);

// File: tb/lic_errstat_tb.sv
`timescale 1ns/1ps
module lic_errstat_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  err_evt = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        x2_mode = 1'b0;
   logic [31:0] lvt_err = 32'h0000_0030;
   logic [31:0] reg_rdata;
   logic        irq_req;
   logic [7:0]  irq_vec;
   logic        illegal_wr;

   int checks = 0;
   int fails  = 0;
   logic [7:0] m_pend = '0;
   logic [7:0] m_vis  = '0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lic_errstat u_dut (
      .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .x2_mode(x2_mode), .lvt_err(lvt_err),
      .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
      .illegal_wr(illegal_wr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One cycle: drive at the falling edge, compute the expectation from the
   // requirements, then sample just after the rising edge.
   task automatic cyc(input string tag, input logic [7:0] evt, input logic wr,
                      input logic [31:0] wd, input logic x2, input logic [31:0] lvt);
      logic [7:0] base;
      logic       fire;
      logic       e_irq;
      logic       e_ill;
      @(negedge clk);
      err_evt = evt; reg_wr = wr; reg_wdata = wd; x2_mode = x2; lvt_err = lvt;
      base  = wr ? 8'h00 : m_pend;                     // R11
      fire  = (evt != 0) && (base == 0);               // R5 R6
      e_irq = fire && !lvt[16];                        // R8
      e_ill = wr && x2 && (wd != 0);                   // R4
      if (wr) m_vis = m_pend;                          // R3
      m_pend = base | evt | ((fire && lvt[7:0] < 16) ? 8'h40 : 8'h00); // R9
      @(posedge clk); #1;
      chk({tag, " R2 R3 R10 rdata"}, reg_rdata, {24'h0, m_vis});
      chk({tag, " R5 R6 R8 irq"}, {31'h0, irq_req}, {31'h0, e_irq});
      chk({tag, " R4 flag"}, {31'h0, illegal_wr}, {31'h0, e_ill});
      if (e_irq) chk({tag, " R7 vec"}, {24'h0, irq_vec}, {24'h0, lvt[7:0]});
   endtask

   task automatic idle_wr(input string tag);
      cyc(tag, 8'h00, 1'b1, 32'h0, 1'b0, 32'h0000_0030);
   endtask

   initial begin
      #(200000 * 5.0);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset rdata", reg_rdata, 32'h0);
      chk("R1 reset irq", {31'h0, irq_req}, 32'h0);
      chk("R1 reset flag", {31'h0, illegal_wr}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 after reset rdata", reg_rdata, 32'h0);

      // R2 R3 R10: every single-bit and the full event pattern, snapshot via write
      for (int b = 0; b < 8; b++) begin
         cyc("R10 single", 8'(1 << b), 1'b0, 32'h0, 1'b0, 32'h0000_0040);
         cyc("R2 hold", 8'h00, 1'b0, 32'h0, 1'b0, 32'h0000_0040);
         cyc("R3 latch", 8'h00, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0000_0040);
         idle_wr("R3 clear");
      end

      // R5 R6: all 256 patterns against empty and non-empty pending
      for (int p = 0; p < 256; p++) begin
         cyc("R5 first", 8'(p), 1'b0, 32'h0, 1'b0, 32'h0000_0020 + 32'(p % 200));
         cyc("R6 second", 8'(p ^ 8'h5A), 1'b0, 32'h0, 1'b0, 32'h0000_0021);
         cyc("R6 repeat", 8'(p), 1'b0, 32'h0, 1'b0, 32'h0000_0022);
         cyc("R3 latch", 8'h00, 1'b1, 32'(p), 1'b0, 32'h0000_0022);
      end

      // R7 R8 R9: vectors 0..31, mask clear and set
      for (int m = 0; m < 2; m++) begin
         for (int v = 0; v < 32; v++) begin
            idle_wr("R9 arm");
            cyc("R9 vec", 8'h02, 1'b0, 32'h0, 1'b0, (32'(m) << 16) | 32'(v));
            cyc("R8 after", 8'h08, 1'b0, 32'h0, 1'b0, 32'(v));
            cyc("R9 latch", 8'h00, 1'b1, 32'h0, 1'b0, 32'h0000_0030);
         end
      end

      // R4: write data and mode combinations
      for (int k = 0; k < 8; k++) begin
         cyc("R4 evt", 8'h80, 1'b0, 32'h0, 1'b0, 32'h0000_0050);
         cyc("R4 write", 8'h00, 1'b1, (k % 2) ? 32'(1 << (k * 4)) : 32'h0, 1'(k / 4), 32'h0000_0050);
         cyc("R4 idle", 8'h00, 1'b0, 32'h0, 1'(k / 4), 32'h0000_0050);
      end

      // R11: event in the same cycle as a write
      cyc("R11 pre", 8'h01, 1'b0, 32'h0, 1'b0, 32'h0000_0040);
      cyc("R11 same", 8'h10, 1'b1, 32'h0, 1'b0, 32'h0000_0041);
      cyc("R11 same2", 8'h20, 1'b1, 32'h0, 1'b1, 32'h0000_0042);
      cyc("R11 same3", 8'h04, 1'b1, 32'h1, 1'b1, 32'h0000_0005);
      idle_wr("R11 drain");
      idle_wr("R11 empty");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule